// File: doc/BRIEF.md
# Synchronous Serial Port with Threshold-Flagged Receive

This block is a single-slot synchronous serial port. An external bit clock and a frame sync, both synchronous to the system clock, set the serial timing. The block finds their transitions by edge detection. Each frame carries one 8-bit word, most significant bit first. The frame sync is high for the whole word, starting with its first bit. Transmit and receive run in the same frame: the word in the transmit holding register goes out on `sdo`, and the bits on `sdi` are gathered into a receive word.

A finished receive word goes into one of two places. With the queue off, it goes into a single receive slot. With the queue on, it goes into an 8-entry receive queue. The queue has a programmable threshold. The threshold sets the full flag, which can raise the interrupt. In queue mode the threshold also caps the number of words the queue accepts: a word that arrives while the level is at the threshold is dropped and flagged as an overrun. The host reaches the block through a small register port: transmit/receive data at address 0, control at address 1, and status at address 2.

Top module: `ssp_port`

## Requirements
- R1: After reset, `sdo` is 0, `irq` is 0 and the status register (address 2) reads 0x00.
- R2: A frame starts on a bit-clock rising edge that sees `fsync` high while the transmitter is idle. At that edge the transmit holding register (written at address 0) is loaded. Its 8 bits appear on `sdo` MSB first, each one updated one system clock after a bit-clock rising edge. The first rising edge without a frame start drives `sdo` low.
- R3: If the host has not written address 0 since the last load, a frame start resends the previous word and sets status bit 2 (transmit underrun). Status bit 2 stays set until the host writes 1 to that bit at address 2.
- R4: `sdi` is sampled on bit-clock falling edges while `fsync` is high, MSB first. The word is handed to the receive side at the 8th sample.
- R5: With the queue off (control bit 0 = 0), the receive side holds one word. A read of address 0 returns that word and frees the slot. Status bits [7:4] show the number of held words.
- R6: With the queue off, a word that completes while the held word is unread is dropped. The held word is kept, and status bit 1 (overrun) is set. Status bit 1 stays set until the host writes 1 to that bit at address 2.
- R7: With the queue on (control bit 0 = 1), words are read back from address 0 in arrival order. The queue holds up to 8 words, and status bits [7:4] give the level.
- R8: Control bits [6:4] hold the threshold minus one (1 to 8). With the queue on, status bit 0 (full) is 1 exactly while the level is at or above the threshold. It clears as soon as reads bring the level below the threshold.
- R9: With the queue on, a word that completes while the level is already at the threshold is dropped. The stored words are kept, and status bit 1 is set.
- R10: `irq` is high only while the queue is on, control bit 1 (receive interrupt enable) is set, control bit 2 (full interrupt enable) is set, and the full flag is set.
- R11: A host read of address 0 in the same system clock as a word completion counts as done first: no overrun is flagged, and the new word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops receive data at address 0) |
| host_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data for `host_addr` |
| bclk | input | 1 | Continuous bit clock, synchronous to `clk` |
| fsync | input | 1 | Word-length frame sync, high with the first bit |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data |
| irq | output | 1 | Receive threshold interrupt |

## Verification
A host read of the receive data and the completion of a new receive word can fall in the same system clock. The outcome of that collision decides whether an overrun is flagged. The bench provokes it by raising the read strobe in the same cycle as the final bit-clock falling edge of a frame, while the earlier word is still unread. The result passes only if the status shows no overrun and a follow-up read returns the word that completed during the collision.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int SSP_WORD_W = 8;
  localparam int SSP_DEPTH  = 8;

  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_STAT = 2'd2
  } ssp_addr_e;

  localparam int CTRL_QEN  = 0;
  localparam int CTRL_RIE  = 1;
  localparam int CTRL_FEN  = 2;
  localparam int CTRL_THR  = 4;
  localparam int STAT_FULL = 0;
  localparam int STAT_OVR  = 1;
  localparam int STAT_UND  = 2;
  localparam int STAT_LVL  = 4;
endpackage

// File: rtl/ssp_edge.sv
module ssp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic sig_q, sig_n;

  always_comb sig_n = sig;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_n;

  assign rise = sig & ~sig_q;
  assign fall = ~sig & sig_q;
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_rise,
  input  logic              fs,
  input  logic [WORD_W-1:0] tx_word,
  output logic              start,
  output logic              sdo
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              sdo_q, sdo_n;

  always_comb begin
    start = bclk_rise & fs & (cnt_q == '0);
    sh_n  = sh_q;
    cnt_n = cnt_q;
    sdo_n = sdo_q;
    if (start) begin
      sh_n  = tx_word << 1;
      sdo_n = tx_word[WORD_W-1];
      cnt_n = CNT_W'(WORD_W - 1);
    end else if (bclk_rise && cnt_q != '0) begin
      sdo_n = sh_q[WORD_W-1];
      sh_n  = sh_q << 1;
      cnt_n = cnt_q - 1'b1;
    end else if (bclk_rise) begin
      sdo_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      sdo_q <= sdo_n;
    end

  assign sdo = sdo_q;

  AST_TX_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_rise && !fs && cnt_q == '0) |=> !sdo_q); // R2
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_fall,
  input  logic              fs,
  input  logic              sdi,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              take;

  always_comb begin
    take  = bclk_fall & fs;
    word  = {sh_q[WORD_W-2:0], sdi};
    done  = take & (cnt_q == CNT_W'(WORD_W - 1));
    sh_n  = take ? word : sh_q;
    cnt_n = cnt_q;
    if (take) cnt_n = done ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end

  AST_RX_HOLD_OUT_OF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !fs |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/ssp_rxq.sv
module ssp_rxq #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 8,
  localparam int PW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_en,
  input  logic [PW-1:0]     thr_m1,
  input  logic              done,
  input  logic [WORD_W-1:0] word,
  input  logic              pop_req,
  input  logic              ovr_clr,
  output logic [WORD_W-1:0] head,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              ovr
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wptr_q, wptr_n, rptr_q, rptr_n;
  logic [LVL_W-1:0]  lvl_q, lvl_n, lvl_eff, cap;
  logic              ovr_q, ovr_n, pop, accept;

  always_comb begin
    cap     = q_en ? (LVL_W'(thr_m1) + 1'b1) : LVL_W'(1);
    pop     = pop_req & (lvl_q != '0);
    lvl_eff = lvl_q - LVL_W'(pop);
    accept  = done & (lvl_eff < cap);
    lvl_n   = lvl_eff + LVL_W'(accept);
    wptr_n  = wptr_q;
    rptr_n  = rptr_q;
    if (accept) wptr_n = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop)    rptr_n = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    ovr_n   = (done & ~accept) | (ovr_q & ~ovr_clr);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      lvl_q  <= lvl_n;
      ovr_q  <= ovr_n;
    end

  always_ff @(posedge clk)
    if (accept) mem[wptr_q] <= word;

  assign head  = mem[rptr_q];
  assign level = lvl_q;
  assign full  = q_en & (lvl_q >= cap);
  assign ovr   = ovr_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(DEPTH)); // R7
  AST_LEVEL_MOVES_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !pop_req) |=> $stable(lvl_q)); // R7
  AST_OVR_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(done)); // R6
  AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (lvl_q != '0)); // R8
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int WORD_W = SSP_WORD_W,
  parameter int DEPTH  = SSP_DEPTH,
  localparam int PW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              sdi,
  output logic              sdo,
  output logic              irq
);
  logic              bclk_rise, bclk_fall, tx_start, rx_done, q_full, q_ovr;
  logic [WORD_W-1:0] rx_word, rx_head;
  logic [LVL_W-1:0]  q_level;
  logic [WORD_W-1:0] hold_q, hold_n, ctrl_q, ctrl_n, stat;
  logic              fresh_q, fresh_n, und_q, und_n;
  logic              wr_data, wr_ctrl, wr_stat, rd_data;

  ssp_edge u_edge (.clk(clk), .rst_n(rst_n), .sig(bclk), .rise(bclk_rise), .fall(bclk_fall));

  ssp_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .fs(fsync),
    .tx_word(hold_q), .start(tx_start), .sdo(sdo));

  ssp_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bclk_fall(bclk_fall), .fs(fsync),
    .sdi(sdi), .done(rx_done), .word(rx_word));

  ssp_rxq #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .q_en(ctrl_q[CTRL_QEN]),
    .thr_m1(ctrl_q[CTRL_THR +: PW]), .done(rx_done), .word(rx_word),
    .pop_req(rd_data), .ovr_clr(wr_stat & host_wdata[STAT_OVR]),
    .head(rx_head), .level(q_level), .full(q_full), .ovr(q_ovr));

  always_comb begin
    wr_data = host_wr & (host_addr == ADDR_DATA);
    wr_ctrl = host_wr & (host_addr == ADDR_CTRL);
    wr_stat = host_wr & (host_addr == ADDR_STAT);
    rd_data = host_rd & (host_addr == ADDR_DATA);
    hold_n  = wr_data ? host_wdata : hold_q;
    ctrl_n  = wr_ctrl ? host_wdata : ctrl_q;
    fresh_n = wr_data | (fresh_q & ~tx_start);
    und_n   = (tx_start & ~fresh_q) | (und_q & ~(wr_stat & host_wdata[STAT_UND]));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_q  <= '0;
      ctrl_q  <= '0;
      fresh_q <= 1'b0;
      und_q   <= 1'b0;
    end else begin
      hold_q  <= hold_n;
      ctrl_q  <= ctrl_n;
      fresh_q <= fresh_n;
      und_q   <= und_n;
    end

  always_comb begin
    stat = '0;
    stat[STAT_FULL] = q_full;
    stat[STAT_OVR]  = q_ovr;
    stat[STAT_UND]  = und_q;
    stat[STAT_LVL +: LVL_W] = q_level;
    case (host_addr)
      ADDR_DATA: host_rdata = rx_head;
      ADDR_CTRL: host_rdata = ctrl_q;
      ADDR_STAT: host_rdata = stat;
      default:   host_rdata = '0;
    endcase
  end

  assign irq = ctrl_q[CTRL_QEN] & ctrl_q[CTRL_RIE] & ctrl_q[CTRL_FEN] & q_full;

  AST_UNDERRUN_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(und_q) |-> $past(tx_start)); // R3
  AST_IRQ_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (q_level != '0)); // R10
endmodule

// File: tb/ssp_port_tb.sv
module ssp_port_tb;
  localparam int CLK_P = 10;

  logic       clk, rst_n, host_wr, host_rd, bclk, fsync, sdi, sdo, irq;
  logic [1:0] host_addr;
  logic [7:0] host_wdata, host_rdata;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];
  logic [7:0] last_tx = 8'h00;
  logic [7:0] mon_sh;
  int mon_cnt = 0;

  ssp_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bclk(bclk), .fsync(fsync), .sdi(sdi), .sdo(sdo), .irq(irq));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic reg_rd(logic [1:0] a, bit pop, output logic [7:0] d);
    @(negedge clk); host_rd = pop; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic rd_stat(string req, logic [7:0] exp);
    logic [7:0] v;
    reg_rd(2'd2, 1'b0, v);
    chk(req, v, exp);
  endtask

  // scoreboard pop for received data
  task automatic rd_rx(string req);
    logic [7:0] v;
    reg_rd(2'd0, 1'b1, v);
    chk(req, v, exp_rx.pop_front());
  endtask

  task automatic frame(bit reload, logic [7:0] tx, logic [7:0] rx, bit rd_last);
    if (reload) begin reg_wr(2'd0, tx); last_tx = tx; end
    exp_tx.push_back(last_tx);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); bclk = 1'b1; fsync = 1'b1; sdi = rx[7-i];
      repeat (3) @(negedge clk);
      bclk = 1'b0;
      if (rd_last && i == 7) begin host_rd = 1'b1; host_addr = 2'd0; end
      @(negedge clk); host_rd = 1'b0;
      repeat (2) @(negedge clk);
    end
    fsync = 1'b0;
    @(negedge clk); bclk = 1'b1;
    repeat (3) @(negedge clk); bclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: rebuild transmitted words and compare with the scoreboard
  always @(negedge bclk) begin
    if (fsync) begin
      mon_sh = {mon_sh[6:0], sdo};
      mon_cnt++;
      if (mon_cnt == 8) begin
        mon_cnt = 0;
        if (exp_tx.size() == 0) chk("R2 tx unexpected word", mon_sh, 0);
        else chk("R2/R3 tx word", mon_sh, exp_tx.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    bclk = 0; fsync = 0; sdi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sdo", sdo, 0);
    chk("R1 irq", irq, 0);
    rd_stat("R1 status", 8'h00);

    // R4 R5: single-slot receive
    frame(1, 8'hA5, 8'h3C, 0); exp_rx.push_back(8'h3C);
    rd_rx("R4 R5 rx word");
    rd_stat("R5 status after read", 8'h00);
    chk("R2 sdo low after frame", sdo, 0);

    // R3: underrun resend
    frame(0, 8'h00, 8'h81, 0); exp_rx.push_back(8'h81);
    rd_stat("R3 R5 underrun and level", 8'h14);
    rd_rx("R5 rx word");
    reg_wr(2'd2, 8'h04);
    rd_stat("R3 underrun cleared", 8'h00);

    // R6: overrun with queue off
    frame(1, 8'h11, 8'h55, 0); exp_rx.push_back(8'h55);
    frame(1, 8'h22, 8'h66, 0);
    rd_stat("R6 overrun set", 8'h12);
    rd_rx("R6 held word kept");
    reg_wr(2'd2, 8'h02);
    rd_stat("R6 overrun cleared", 8'h00);

    // R11: read in the completion cycle
    frame(1, 8'h33, 8'h12, 0);
    frame(1, 8'h44, 8'h34, 1); exp_rx.push_back(8'h34);
    rd_stat("R11 no overrun", 8'h10);
    rd_rx("R11 new word stored");

    // R7 R8 R9 R10: queue with threshold 3
    reg_wr(2'd1, 8'h27);
    frame(1, 8'h01, 8'hA1, 0); exp_rx.push_back(8'hA1);
    frame(1, 8'h02, 8'hA2, 0); exp_rx.push_back(8'hA2);
    rd_stat("R8 below threshold", 8'h20);
    chk("R10 irq low below threshold", irq, 0);
    frame(1, 8'h03, 8'hA3, 0); exp_rx.push_back(8'hA3);
    rd_stat("R7 R8 at threshold", 8'h31);
    chk("R10 irq high", irq, 1);
    reg_wr(2'd1, 8'h25);
    chk("R10 irq gated by enable", irq, 0);
    reg_wr(2'd1, 8'h27);
    frame(1, 8'h04, 8'hA4, 0);
    rd_stat("R9 overrun at threshold", 8'h33);
    rd_rx("R7 R9 order kept");
    rd_stat("R8 full clears below threshold", 8'h22);
    chk("R10 irq drops", irq, 0);
    rd_rx("R7 second");
    rd_rx("R7 third");
    reg_wr(2'd2, 8'h02);
    rd_stat("R9 overrun cleared", 8'h00);

    // R7 R8: threshold 8 fills whole queue
    reg_wr(2'd1, 8'h77);
    for (int k = 0; k < 8; k++) begin
      frame(1, 8'(k + 8'h50), 8'(8'hC0 + k), 0);
      exp_rx.push_back(8'(8'hC0 + k));
      if (k == 6) rd_stat("R8 seven below threshold 8", 8'h70);
    end
    rd_stat("R7 R8 full at depth", 8'h81);
    for (int k = 0; k < 8; k++) rd_rx("R7 deep order");
    rd_stat("R7 drained", 8'h00);
    chk("R2 all tx words seen", exp_tx.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule